// File: doc/BRIEF.md
# Page-Mode ROM Pin Emulator

This block stands in for an asynchronous page-mode read-only memory inside an FPGA, so that a host memory controller can be tested against it. It runs on the fabric clock and samples the address bus, the active-low chip and output enables, and the width select on every edge. From them it drives a 16-lane data bus, with one enable bit per lane in place of real three-state pads, and a flag that shows whether the data on the bus has been valid long enough. The bus follows the memory's mode table: standby, output disabled, 16-bit read and 8-bit read. In 8-bit mode the top data lane becomes an extra, lowest address bit.

Access timing is counted in clocks since the last relevant change. A change in the upper address bits needs the long random-access wait. A change that stays inside the page needs only the short page wait. A falling chip enable or a falling output enable starts its own wait. Until every pending wait has run out, the lanes keep showing the last data that was presented as valid, and the flag stays low. A bench can therefore catch a host that samples too early. The stored contents are a fixed arithmetic function of the address, so no file is needed.

Every input is registered once before use. Outputs answer the state sampled at the previous clock edge. The pins here are plain control and data lines with no handshake, so no back-pressure applies.

Top module: `prom_page_emu`

## Requirements
- R1: While the sampled chip_en_n is 1 (standby), dout_oe is 0 and dout_valid is 0, whatever the other inputs are. This takes effect at the first clock edge that samples chip_en_n high.
- R2: While the sampled chip_en_n is 0 and out_en_n is 1, dout_oe is 0 and dout_valid is 0.
- R3: With both enables low and wide_mode 1, dout_oe is 16'hFFFF. Once dout_valid is 1, dout equals the content word of rom_addr. The content word is ((A[15:0] ^ A[31:16] ^ A[47:32] ^ A[63:48]) * 16'h9E37 + 16'h5A3C) mod 2^16, where A is rom_addr zero-extended to 64 bits.
- R4: With both enables low and wide_mode 0, dout_oe is 16'h00FF. lane15_in is the extra lowest address bit: 0 puts the low byte of the content word on dout[7:0], and 1 puts the high byte there. dout[15:8] is 0 whenever dout_valid is 1.
- R5: A change of rom_addr[ADDR_W-1:PAGE_BITS] holds dout_valid low for RAND_CYC clock cycles, counted from the edge that samples the change. dout_valid rises after the following edge if nothing else is pending.
- R6: A change only inside the page holds dout_valid low for PAGE_CYC cycles. Such a change is a change of rom_addr[PAGE_BITS-1:0], of wide_mode, or of lane15_in while wide_mode is 0.
- R7: A falling chip_en_n starts a CE_CYC wait and a falling out_en_n starts an OE_CYC wait. When several waits are pending, dout_valid rises only after the longest one ends.
- R8: While dout_valid is 0, dout holds the last value it showed with dout_valid high, or 0 if none has been shown since reset.
- R9: While wide_mode is 1, changes on lane15_in have no effect on dout, dout_oe or dout_valid.
- R10: During reset, dout, dout_oe and dout_valid are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rom_addr | input | ADDR_W | Word address from the host |
| chip_en_n | input | 1 | Active-low chip enable |
| out_en_n | input | 1 | Active-low output enable |
| wide_mode | input | 1 | 1 selects 16-bit reads, 0 selects 8-bit reads |
| lane15_in | input | 1 | Lowest byte-address bit in 8-bit mode, ignored in 16-bit mode |
| dout | output | 16 | Data lanes |
| dout_oe | output | 16 | Per-lane drive enable; 0 stands for high impedance |
| dout_valid | output | 1 | Data on enabled lanes has met every pending access wait |

## Verification
The bench measures the exact cycle in which dout_valid rises after upper-address, in-page, chip-enable and output-enable changes. A design that used the wrong counter, or that was off by one, would raise the flag a cycle early or late. It overlaps an output-enable wait with a random-access wait to show that the longest wait decides; a design that let the last event override the others would release the short wait first. During each wait it checks that stale data is held, which catches a design that puts new data on the bus before it is valid. It also checks the 8-bit lane map and the byte order selected by lane15_in, and that lane15_in is ignored in 16-bit mode. Swapped bytes, or a spurious page wait, would show up there.

// File: rtl/prom_emu_pkg.sv
package prom_emu_pkg;

  typedef enum logic [1:0] {
    LM_STANDBY = 2'd0,
    LM_OFF     = 2'd1,
    LM_WORD    = 2'd2,
    LM_BYTE    = 2'd3
  } lane_mode_e;

  localparam int unsigned DATA_W = 16;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned WAIT_KINDS = 4;

  // Fold the address into 16 bits, then scramble it with a multiply and an offset.
  function automatic logic [DATA_W-1:0] content_word(input logic [63:0] a);
    logic [DATA_W-1:0] fold;
    fold = '0;
    for (int i = 0; i < 4; i++) begin
      fold = fold ^ a[i*16 +: 16];
    end
    return DATA_W'(fold * 16'h9E37 + 16'h5A3C);
  endfunction

endpackage

// File: rtl/prom_pin_sampler.sv
module prom_pin_sampler #(
  parameter int unsigned ADDR_W    = 22,
  parameter int unsigned PAGE_BITS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ce_n_i,
  input  logic              oe_n_i,
  input  logic              wide_i,
  input  logic              xbit_i,
  output logic [ADDR_W-1:0] addr_q,
  output logic              ce_n_q,
  output logic              oe_n_q,
  output logic              wide_q,
  output logic              xbit_q,
  output logic              ev_upper,
  output logic              ev_page,
  output logic              ev_ce_fall,
  output logic              ev_oe_fall
);

  localparam int unsigned UP_W = ADDR_W - PAGE_BITS;

  logic [ADDR_W-1:0] addr_p;
  logic              ce_n_p;
  logic              oe_n_p;
  logic              wide_p;
  logic              xbit_p;

  // First stage: the pins as seen at this edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      ce_n_q <= 1'b1;
      oe_n_q <= 1'b1;
      wide_q <= 1'b1;
      xbit_q <= 1'b0;
    end else begin
      addr_q <= addr_i;
      ce_n_q <= ce_n_i;
      oe_n_q <= oe_n_i;
      wide_q <= wide_i;
      xbit_q <= xbit_i;
    end
  end

  // Second stage: the pins one edge earlier, used for change detection.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_p <= '0;
      ce_n_p <= 1'b1;
      oe_n_p <= 1'b1;
      wide_p <= 1'b1;
      xbit_p <= 1'b0;
    end else begin
      addr_p <= addr_q;
      ce_n_p <= ce_n_q;
      oe_n_p <= oe_n_q;
      wide_p <= wide_q;
      xbit_p <= xbit_q;
    end
  end

  logic up_diff;
  logic low_diff;
  logic x_diff;

  always_comb begin
    up_diff  = addr_q[ADDR_W-1 -: UP_W] != addr_p[ADDR_W-1 -: UP_W];
    low_diff = addr_q[PAGE_BITS-1:0] != addr_p[PAGE_BITS-1:0];
    // The extra bit only counts as an address bit in 8-bit mode.
    x_diff   = !wide_q && (xbit_q != xbit_p);
    ev_upper   = up_diff;
    ev_page    = low_diff || (wide_q != wide_p) || x_diff;
    ev_ce_fall = ce_n_p && !ce_n_q;
    ev_oe_fall = oe_n_p && !oe_n_q;
  end

endmodule

// File: rtl/prom_wait_timer.sv
module prom_wait_timer #(
  parameter int unsigned LIMIT = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);

  localparam int unsigned CW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
  localparam logic [CW-1:0] RELOAD = CW'(LIMIT - 1);

  logic [CW-1:0] left;

  // The cycle of the event is one waiting cycle; LIMIT-1 more follow it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left <= '0;
    end else if (start) begin
      left <= RELOAD;
    end else if (left != '0) begin
      left <= left - 1'b1;
    end
  end

  assign busy = start || (left != '0);

endmodule

// File: rtl/prom_lane_driver.sv
module prom_lane_driver
  import prom_emu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n_q,
  input  logic              oe_n_q,
  input  logic              wide_q,
  input  logic              xbit_q,
  input  logic [DATA_W-1:0] word_q,
  input  logic              wait_busy,
  output logic [DATA_W-1:0] dout,
  output logic [DATA_W-1:0] dout_oe,
  output logic              dout_valid
);

  lane_mode_e        mode;
  logic [DATA_W-1:0] fresh;
  logic [DATA_W-1:0] held;
  logic              active;

  always_comb begin
    if (ce_n_q)      mode = LM_STANDBY;
    else if (oe_n_q) mode = LM_OFF;
    else if (wide_q) mode = LM_WORD;
    else             mode = LM_BYTE;
  end

  always_comb begin
    fresh   = '0;
    dout_oe = '0;
    unique case (mode)
      LM_WORD: begin
        fresh   = word_q;
        dout_oe = '1;
      end
      LM_BYTE: begin
        fresh[BYTE_W-1:0]  = xbit_q ? word_q[DATA_W-1:BYTE_W] : word_q[BYTE_W-1:0];
        dout_oe[BYTE_W-1:0] = '1;
      end
      default: begin
        fresh   = '0;
        dout_oe = '0;
      end
    endcase
  end

  assign active     = (mode == LM_WORD) || (mode == LM_BYTE);
  assign dout_valid = active && !wait_busy;
  assign dout       = dout_valid ? fresh : held;

  // Stale data stays on the lanes until the new access has matured.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held <= '0;
    end else if (dout_valid) begin
      held <= fresh;
    end
  end

  // R8
  stale_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dout_valid && $past(!dout_valid)) |-> $stable(dout));

endmodule

// File: rtl/prom_page_emu.sv
module prom_page_emu
  import prom_emu_pkg::*;
#(
  parameter int unsigned ADDR_W    = 22,
  parameter int unsigned PAGE_BITS = 3,
  parameter int unsigned RAND_CYC  = 5,
  parameter int unsigned PAGE_CYC  = 2,
  parameter int unsigned CE_CYC    = 5,
  parameter int unsigned OE_CYC    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rom_addr,
  input  logic              chip_en_n,
  input  logic              out_en_n,
  input  logic              wide_mode,
  input  logic              lane15_in,
  output logic [15:0]       dout,
  output logic [15:0]       dout_oe,
  output logic              dout_valid
);

  localparam int unsigned LIMITS [WAIT_KINDS] = '{RAND_CYC, PAGE_CYC, CE_CYC, OE_CYC};

  logic [ADDR_W-1:0]     addr_q;
  logic                  ce_n_q;
  logic                  oe_n_q;
  logic                  wide_q;
  logic                  xbit_q;
  logic [WAIT_KINDS-1:0] events;
  logic [WAIT_KINDS-1:0] busy;
  logic [DATA_W-1:0]     word_q;

  prom_pin_sampler #(
    .ADDR_W   (ADDR_W),
    .PAGE_BITS(PAGE_BITS)
  ) u_sampler (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr_i    (rom_addr),
    .ce_n_i    (chip_en_n),
    .oe_n_i    (out_en_n),
    .wide_i    (wide_mode),
    .xbit_i    (lane15_in),
    .addr_q    (addr_q),
    .ce_n_q    (ce_n_q),
    .oe_n_q    (oe_n_q),
    .wide_q    (wide_q),
    .xbit_q    (xbit_q),
    .ev_upper  (events[0]),
    .ev_page   (events[1]),
    .ev_ce_fall(events[2]),
    .ev_oe_fall(events[3])
  );

  // One independent timer per kind of event; the longest outstanding one decides.
  for (genvar g = 0; g < WAIT_KINDS; g++) begin : g_wait
    prom_wait_timer #(
      .LIMIT(LIMITS[g])
    ) u_timer (
      .clk  (clk),
      .rst_n(rst_n),
      .start(events[g]),
      .busy (busy[g])
    );
  end

  assign word_q = content_word(64'(addr_q));

  prom_lane_driver u_lanes (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_n_q    (ce_n_q),
    .oe_n_q    (oe_n_q),
    .wide_q    (wide_q),
    .xbit_q    (xbit_q),
    .word_q    (word_q),
    .wait_busy (|busy),
    .dout      (dout),
    .dout_oe   (dout_oe),
    .dout_valid(dout_valid)
  );

  // R1
  standby_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(chip_en_n) |-> (dout_oe == '0 && !dout_valid));

  // R2
  out_off_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!chip_en_n) && $past(out_en_n)) |-> (dout_oe == '0 && !dout_valid));

  // R3
  word_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(!chip_en_n && !out_en_n && wide_mode)) |-> (dout_oe == 16'hFFFF));

  // R4
  byte_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(!chip_en_n && !out_en_n && !wide_mode)) |-> (dout_oe == 16'h00FF));

  // R4
  byte_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_valid && dout_oe == 16'h00FF) |-> (dout[15:8] == 8'h00));

  // R5
  upper_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(rst_n, 2) &&
     $past(rom_addr[ADDR_W-1:PAGE_BITS]) != $past(rom_addr[ADDR_W-1:PAGE_BITS], 2))
    |-> !dout_valid);

endmodule

// File: tb/prom_page_emu_test.sv
module prom_page_emu_test;

  localparam int RAND_L = 5;
  localparam int PAGE_L = 2;
  localparam int CE_L   = 5;
  localparam int OE_L   = 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [21:0] rom_addr;
  logic        chip_en_n;
  logic        out_en_n;
  logic        wide_mode;
  logic        lane15_in;
  logic [15:0] dout;
  logic [15:0] dout_oe;
  logic        dout_valid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  prom_page_emu uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .rom_addr  (rom_addr),
    .chip_en_n (chip_en_n),
    .out_en_n  (out_en_n),
    .wide_mode (wide_mode),
    .lane15_in (lane15_in),
    .dout      (dout),
    .dout_oe   (dout_oe),
    .dout_valid(dout_valid)
  );

  function automatic logic [15:0] exp_word(input logic [21:0] a);
    logic [15:0] f;
    f = a[15:0] ^ 16'(a[21:16]);
    return 16'(f * 16'h9E37 + 16'h5A3C);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Called right after inputs were driven at a negedge.
  task automatic expect_wait(input string req, input int lim,
                             input bit chk_stale, input logic [15:0] stale);
    repeat (lim) @(posedge clk);
    @(negedge clk);
    check(!dout_valid, req, "valid during wait", 16'(dout_valid), 16'h0);
    if (chk_stale) check(dout == stale, "R8", "stale data held", dout, stale);
    @(negedge clk);
    check(dout_valid, req, "valid after wait", 16'(dout_valid), 16'h1);
  endtask

  task automatic t_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(dout == 16'h0, "R10", "dout in reset", dout, 16'h0);
    check(dout_oe == 16'h0, "R10", "oe in reset", dout_oe, 16'h0);
    check(!dout_valid, "R10", "valid in reset", 16'(dout_valid), 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(dout_oe == 16'h0, "R1", "oe idle after reset", dout_oe, 16'h0);
  endtask

  task automatic t_enable_read(input logic [21:0] a);
    rom_addr = a; chip_en_n = 1'b0; out_en_n = 1'b0;
    expect_wait("R7", CE_L, 1'b1, 16'h0);
    check(dout_oe == 16'hFFFF, "R3", "word lanes", dout_oe, 16'hFFFF);
    check(dout == exp_word(a), "R3", "word data", dout, exp_word(a));
  endtask

  task automatic t_page(input logic [21:0] a);
    logic [15:0] old = dout;
    rom_addr = a;
    expect_wait("R6", PAGE_L, 1'b1, old);
    check(dout == exp_word(a), "R6", "page data", dout, exp_word(a));
  endtask

  task automatic t_upper(input logic [21:0] a);
    logic [15:0] old = dout;
    rom_addr = a;
    expect_wait("R5", RAND_L, 1'b1, old);
    check(dout == exp_word(a), "R5", "random data", dout, exp_word(a));
  endtask

  task automatic t_out_toggle();
    out_en_n = 1'b1;
    @(negedge clk);
    check(dout_oe == 16'h0, "R2", "oe when disabled", dout_oe, 16'h0);
    check(!dout_valid, "R2", "valid when disabled", 16'(dout_valid), 16'h0);
    out_en_n = 1'b0;
    expect_wait("R7", OE_L, 1'b0, 16'h0);
    check(dout == exp_word(rom_addr), "R7", "data after oe", dout, exp_word(rom_addr));
  endtask

  task automatic t_longest(input logic [21:0] a);
    out_en_n = 1'b1;
    @(negedge clk);
    out_en_n = 1'b0; rom_addr = a;
    expect_wait("R7", RAND_L, 1'b0, 16'h0);
    check(dout == exp_word(a), "R7", "data after overlap", dout, exp_word(a));
  endtask

  task automatic t_standby();
    chip_en_n = 1'b1;
    @(negedge clk);
    check(dout_oe == 16'h0, "R1", "oe in standby", dout_oe, 16'h0);
    check(!dout_valid, "R1", "valid in standby", 16'(dout_valid), 16'h0);
    wide_mode = 1'b0; out_en_n = 1'b1;
    @(negedge clk);
    out_en_n = 1'b0;
    @(negedge clk);
    check(dout_oe == 16'h0, "R1", "oe standby other pins", dout_oe, 16'h0);
    wide_mode = 1'b1; chip_en_n = 1'b0;
    expect_wait("R7", CE_L, 1'b0, 16'h0);
  endtask

  task automatic t_word_ignore_x();
    logic [15:0] ref_d = dout;
    for (int i = 0; i < 3; i++) begin
      lane15_in = ~lane15_in;
      @(negedge clk);
      check(dout_valid && dout == ref_d && dout_oe == 16'hFFFF, "R9",
            "lane15 ignored in word mode", dout, ref_d);
    end
  endtask

  task automatic t_byte();
    logic [15:0] w = exp_word(rom_addr);
    wide_mode = 1'b0; lane15_in = 1'b0;
    expect_wait("R6", PAGE_L, 1'b0, 16'h0);
    check(dout_oe == 16'h00FF, "R4", "byte lanes", dout_oe, 16'h00FF);
    check(dout == {8'h00, w[7:0]}, "R4", "low byte", dout, {8'h00, w[7:0]});
    lane15_in = 1'b1;
    expect_wait("R6", PAGE_L, 1'b1, {8'h00, w[7:0]});
    check(dout == {8'h00, w[15:8]}, "R4", "high byte", dout, {8'h00, w[15:8]});
    rom_addr = 22'h15_7A18;
    w = exp_word(22'h15_7A18);
    expect_wait("R5", RAND_L, 1'b0, 16'h0);
    check(dout == {8'h00, w[15:8]}, "R4", "high byte new row", dout, {8'h00, w[15:8]});
  endtask

  initial begin
    rst_n = 1'b0; rom_addr = '0; chip_en_n = 1'b1; out_en_n = 1'b1;
    wide_mode = 1'b1; lane15_in = 1'b0;
    t_reset();
    @(negedge clk);
    t_enable_read(22'h12_3450);
    t_page(22'h12_3455);
    t_upper(22'h2A_BCD0);
    t_out_toggle();
    t_longest(22'h03_0F08);
    t_standby();
    t_word_ignore_x();
    t_byte();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule